// File: doc/BRIEF.md
# Tuning Word Loader and Phase Accumulator

This block is the digital core of a numerically controlled oscillator. A 40-bit control word is assembled in a staging register. Software delivers it either as byte writes on a parallel port or as a bit stream on a serial port. The low 32 bits of the word are the frequency step, so the output frequency is step × f_clk / 2^32. Software computes every step as step = f_out × 2^32 / f_clk. There is no relative increase or decrease command. For example, a step of 163200000 (word 0x0009BA3C00) gives about 2.95 MHz at a 77.76 MHz clock.

The staged word changes nothing until a separate commit strobe moves it into a delay line of committed words. The word reaches the accumulator a fixed number of cycles after its own strobe, in commit order. A commit with an incomplete word is rejected and raises an error flag. The top byte of the word also carries a 5-bit coarse phase offset and a power-down bit. The outputs are the top accumulator phase bits and a valid flag. They feed a sine table outside this block.

Top module: `tuning_nco`

## Requirements
- R1: After reset, `phase_out` is 0, `phase_valid` is 0 and `load_err` is 0. The applied step is 0 until the first commit takes effect.
- R2: On the parallel path, byte writes fill the staging register from the bottom: the first write goes to bits 7:0 and the fifth to bits 39:32. Once five bytes have been taken, further byte writes are ignored. The register only changes when a byte or serial write is taken.
- R3: On the serial path, bits arrive LSB first. The n-th bit taken (counting from 0) lands in bit n, and the word is complete after 40 bits. A byte write in the same cycle takes priority, and the serial bit is dropped.
- R4: A commit is complete if five bytes or 40 serial bits have been taken. An incomplete commit leaves the running frequency unchanged and sets `load_err`. A complete commit clears `load_err`. Every commit resets both fill counters. A byte or bit presented in the same cycle as a commit is discarded.
- R5: If the commit is sampled at clock edge k, the output registered at edge k+18 is the first one computed with the new word. Several commits less than 18 cycles apart each take effect 18 cycles after their own strobe, in order.
- R6: On each cycle the accumulator adds the step (bits 31:0) modulo 2^32, with no saturation. `phase_out` is the top 14 bits of the updated accumulator plus the offset.
- R7: The phase offset is in bits 36:32. It is added as offset × 2^9, modulo 2^14, to the top 14 accumulator bits.
- R8: While bit 39 (power-down) of the applied word is 1, the accumulator is held at 0, `phase_out` is 0 and `phase_valid` is 0. Bits 38:37 are ignored.
- R9: `phase_valid` is 1 from the first output computed with a committed word whose power-down bit is 0.
- R10: With the word 0x0009BA3C00 applied to an accumulator at 0, the m-th output after the change carries the top 14 bits of m × 163200000.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_we | input | 1 | Parallel byte write strobe |
| byte_in | input | 8 | Parallel byte data |
| ser_en | input | 1 | Serial bit enable |
| ser_in | input | 1 | Serial data bit |
| commit | input | 1 | Commit strobe for the staged word |
| phase_out | output | 14 | Phase with offset applied |
| phase_valid | output | 1 | Phase output driven by an active committed word |
| load_err | output | 1 | Last commit was incomplete |

## Verification
The bench loads words over the parallel path, the serial path, and both with idle gaps. Comparing these shows whether byte and bit ordering land in the same staging fields. Short loads and commits that meet a same-cycle write separate a correct complete-word check from one that miscounts or leaks partial data. Power-down words, random offsets and commits closer together than the latency test the delay-line order, the wrap arithmetic and the exact cycle of the change. The known example word pins the step value against the formula.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int FTW_W  = 32;
  localparam int OFFS_W = 5;
  localparam int RSV_W  = 2;
  localparam int CTRL_W = 1 + RSV_W + OFFS_W + FTW_W;

  // Bit 39 power-down, 38:37 ignored, 36:32 offset, 31:0 step.
  typedef struct packed {
    logic              pd;
    logic [RSV_W-1:0]  rsv;
    logic [OFFS_W-1:0] offs;
    logic [FTW_W-1:0]  ftw;
  } tune_word_t;
endpackage

// File: rtl/nco_stager.sv
module nco_stager #(
  parameter int BYTES  = 5,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_we_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    ser_en_i,
  input  logic                    ser_i,
  input  logic                    commit_i,
  output logic                    push_o,
  output logic [BYTES*BYTE_W-1:0] word_o,
  output logic                    err_o
);
  localparam int WORD_W = BYTES * BYTE_W;
  localparam int BC_W   = $clog2(BYTES + 1);
  localparam int NC_W   = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] stage_q;
  logic [BC_W-1:0]   byte_cnt;
  logic [NC_W-1:0]   bit_cnt;
  logic              full;

  assign full   = (byte_cnt == BC_W'(BYTES)) || (bit_cnt == NC_W'(WORD_W));
  assign push_o = commit_i && full;
  assign word_o = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      byte_cnt <= '0;
      bit_cnt  <= '0;
      err_o    <= 1'b0;
    end else if (commit_i) begin
      byte_cnt <= '0;
      bit_cnt  <= '0;
      err_o    <= !full;
    end else if (byte_we_i) begin
      if (byte_cnt < BC_W'(BYTES)) begin
        stage_q[byte_cnt*BYTE_W +: BYTE_W] <= byte_i;
        byte_cnt <= byte_cnt + 1'b1;
      end
    end else if (ser_en_i) begin
      if (bit_cnt < NC_W'(WORD_W)) begin
        stage_q[bit_cnt] <= ser_i;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assert_short_commit_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !full) |=> err_o);
  assert_counters_clear_R4: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (byte_cnt == '0 && bit_cnt == '0));
  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(byte_we_i || ser_en_i) |=> $stable(stage_q));
endmodule

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int W     = 40,
  parameter int DEPTH = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  // Data carries no reset so the chain can map onto shift-register primitives.
  always_ff @(posedge clk) begin
    dat_q[0] <= in_word;
    for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
  end

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= in_valid;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[DEPTH-2:0], in_valid};
      end
    end
  endgenerate

  assign out_valid = vld_q[DEPTH-1];
  assign out_word  = dat_q[DEPTH-1];
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int PHASE_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apply_i,
  input  tune_word_t         word_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               valid_o
);
  localparam int ACC_W = FTW_W;

  tune_word_t         act_q;
  logic               loaded_q;
  logic [ACC_W-1:0]   acc_q, acc_nxt;
  logic [PHASE_W-1:0] offs_ext, ph_nxt;
  logic               unused_rsv;

  assign unused_rsv = ^act_q.rsv;
  assign acc_nxt    = acc_q + act_q.ftw;
  assign offs_ext   = {act_q.offs, {(PHASE_W-OFFS_W){1'b0}}};
  assign ph_nxt     = acc_nxt[ACC_W-1 -: PHASE_W] + offs_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      loaded_q <= 1'b0;
      acc_q    <= '0;
      phase_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (apply_i) begin
        act_q    <= word_i;
        loaded_q <= 1'b1;
      end
      if (act_q.pd) begin
        acc_q   <= '0;
        phase_o <= '0;
        valid_o <= 1'b0;
      end else begin
        acc_q   <= acc_nxt;
        phase_o <= ph_nxt;
        valid_o <= loaded_q;
      end
    end
  end

  assert_pd_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && act_q.pd) |=> (phase_o == '0 && !valid_o));
  assert_valid_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> loaded_q);
endmodule

// File: rtl/tuning_nco.sv
module tuning_nco
  import nco_pkg::*;
#(
  parameter int LATENCY = 18,
  parameter int PHASE_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_we,
  input  logic [7:0]         byte_in,
  input  logic               ser_en,
  input  logic               ser_in,
  input  logic               commit,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_valid,
  output logic               load_err
);
  localparam int BYTE_W   = 8;
  localparam int BYTES    = CTRL_W / BYTE_W;
  localparam int DL_DEPTH = LATENCY - 1;

  logic              push;
  logic [CTRL_W-1:0] staged, delayed;
  logic              apply;

  nco_stager #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .rst(rst), .byte_we_i(byte_we), .byte_i(byte_in),
    .ser_en_i(ser_en), .ser_i(ser_in), .commit_i(commit),
    .push_o(push), .word_o(staged), .err_o(load_err)
  );

  nco_delay_line #(.W(CTRL_W), .DEPTH(DL_DEPTH)) u_dly (
    .clk(clk), .rst(rst), .in_valid(push), .in_word(staged),
    .out_valid(apply), .out_word(delayed)
  );

  nco_phase_core #(.PHASE_W(PHASE_W)) u_core (
    .clk(clk), .rst(rst), .apply_i(apply), .word_i(tune_word_t'(delayed)),
    .phase_o(phase_out), .valid_o(phase_valid)
  );
endmodule

// File: tb/sim_tuning_nco.sv
`timescale 1ns/1ps
module sim_tuning_nco;
  logic clk = 1'b0, rst = 1'b1;
  logic byte_we = 1'b0, ser_en = 1'b0, ser_in = 1'b0, commit = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [13:0] phase_out;
  logic phase_valid, load_err;

  always #5 clk = ~clk;

  tuning_nco u0 (.clk(clk), .rst(rst), .byte_we(byte_we), .byte_in(byte_in),
    .ser_en(ser_en), .ser_in(ser_in), .commit(commit), .phase_out(phase_out),
    .phase_valid(phase_valid), .load_err(load_err));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model built from the requirements.
  logic [39:0] m_stage, m_act;
  logic [31:0] m_acc;
  logic [13:0] m_ph;
  logic        m_val, m_err, m_load;
  int          m_bc, m_nc, ecnt;
  int          q_t [16];
  logic [39:0] q_w [16];
  int          q_h, q_n;

  function automatic logic [13:0] exp_phase(logic [31:0] acc, logic [4:0] off);
    return acc[31:18] + {off, 9'b0};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stage = '0; m_act = '0; m_acc = '0; m_ph = '0; m_val = 0; m_err = 0;
      m_load = 0; m_bc = 0; m_nc = 0; ecnt = 0; q_h = 0; q_n = 0;
    end else begin
      ecnt++;
      if (q_n > 0 && q_t[q_h] == ecnt) begin
        m_act = q_w[q_h]; m_load = 1; q_h = (q_h + 1) % 16; q_n--;
      end
      if (m_act[39]) begin m_acc = '0; m_ph = '0; m_val = 0; end
      else begin
        m_acc = m_acc + m_act[31:0];
        m_ph  = exp_phase(m_acc, m_act[36:32]);
        m_val = m_load;
      end
      if (commit) begin
        if (m_bc == 5 || m_nc == 40) begin
          q_t[(q_h + q_n) % 16] = ecnt + 18; q_w[(q_h + q_n) % 16] = m_stage; q_n++;
          m_err = 0;
        end else m_err = 1;
        m_bc = 0; m_nc = 0;
      end else if (byte_we) begin
        if (m_bc < 5) begin m_stage[m_bc*8 +: 8] = byte_in; m_bc++; end
      end else if (ser_en) begin
        if (m_nc < 40) begin m_stage[m_nc] = ser_in; m_nc++; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (phase_out !== m_ph || phase_valid !== m_val || load_err !== m_err) begin
        fails++;
        $display("FAIL %s (R6/R9/R4 per-cycle) phase %h/%h valid %b/%b err %b/%b (actual/expected)",
                 cur_req, phase_out, m_ph, phase_valid, m_val, load_err, m_err);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic cyc(bit bw, logic [7:0] bv, bit se, bit sv, bit cm);
    byte_we = bw; byte_in = bv; ser_en = se; ser_in = sv; commit = cm;
    @(negedge clk);
    byte_we = 0; ser_en = 0; commit = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0);
  endtask

  task automatic load_par(logic [39:0] w, int nb, bit gaps);
    for (int i = 0; i < nb; i++) begin
      cyc(1, w[(i % 5)*8 +: 8], 0, 0, 0);
      if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
    end
  endtask

  task automatic load_ser(logic [39:0] w, int nb, bit gaps);
    for (int i = 0; i < nb; i++) begin
      cyc(0, 8'h00, 1, w[i % 40], 0);
      if (gaps && ($urandom % 8 == 0)) idle(1);
    end
  endtask

  task automatic do_commit();
    cyc(0, 8'h00, 0, 0, 1);
  endtask

  function automatic logic [39:0] rand_word();
    logic [39:0] w;
    w = {$urandom, $urandom};
    w[39] = ($urandom % 10 == 0);
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 phase after reset", 32'(phase_out), 0);
    check("R1 valid after reset", 32'(phase_valid), 0);
    check("R1 err after reset", 32'(load_err), 0);
    rst = 0;
    idle(4);
    check("R1 idle phase stays 0", 32'(phase_out), 0);

    // R8: power-down word forces the accumulator to zero.
    cur_req = "R8";
    load_par(40'h80_1234_5678, 5, 0); do_commit(); idle(22);
    check("R8 pd valid low", 32'(phase_valid), 0);

    // R10 / R5: known word from accumulator zero.
    cur_req = "R10";
    load_par(40'h00_09BA_3C00, 5, 0); do_commit();
    idle(17);
    check("R5 old word still active at k+17", 32'(phase_valid), 0);
    idle(1);
    check("R5 new word at k+18 (R9 valid)", 32'(phase_valid), 1);
    check("R10 first step", 32'(phase_out), 32'(exp_phase(32'd163200000, 5'd0)));
    idle(9);
    check("R10 tenth step", 32'(phase_out), 32'(exp_phase(32'd1632000000, 5'd0)));

    // R4: short commit rejected.
    cur_req = "R4";
    load_par(40'h00_FFFF_FFFF, 3, 0); do_commit();
    check("R4 short commit flags err", 32'(load_err), 1);
    idle(25);
    load_ser(40'h00_FFFF_FFFF, 39, 0); do_commit();
    check("R4 39-bit serial commit flags err", 32'(load_err), 1);
    idle(20);

    // R3 / R7: serial load with offset.
    cur_req = "R3";
    load_ser(40'h1F_0100_0003, 40, 1); do_commit();
    check("R4 complete commit clears err", 32'(load_err), 0);
    idle(25);
    cur_req = "R7";
    load_ser(40'h65_0040_0001, 40, 0); do_commit(); idle(25);

    // R2: extra byte writes ignored.
    cur_req = "R2";
    load_par(40'h0A_0003_0000, 5, 0);
    cyc(1, 8'hFF, 0, 0, 0); cyc(1, 8'hEE, 0, 0, 0);
    do_commit(); idle(22);

    // R3: byte write wins over serial bit in the same cycle.
    cur_req = "R3";
    for (int i = 0; i < 5; i++) cyc(1, 8'h11 * (i + 1), 1, 1, 0);
    do_commit(); idle(22);

    // R4: write in the commit cycle is discarded and counters reset.
    cur_req = "R4";
    load_par(40'h02_0005_0000, 5, 0);
    cyc(1, 8'h77, 0, 0, 1);
    load_par(40'h00_0100_0000, 4, 0); do_commit();
    check("R4 counters reset by commit", 32'(load_err), 1);
    idle(22);

    // R5: several commits inside one latency window.
    cur_req = "R5";
    for (int j = 0; j < 3; j++) begin load_par(rand_word() & ~40'h80_0000_0000, 5, 0); do_commit(); end
    idle(25);

    // R8: power-down then resume from zero.
    cur_req = "R8";
    load_par(40'hE0_0000_1000, 5, 0); do_commit(); idle(20);
    check("R8 phase held at 0", 32'(phase_out), 0);
    load_par(40'h00_0040_0000, 5, 0); do_commit(); idle(19);
    check("R8 resume from zero", 32'(phase_out), 32'(exp_phase(32'h0080_0000, 5'd0)));

    // Random mix.
    cur_req = "R6";
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom % 8;
      if (op < 4)      begin load_par(rand_word(), 5, 1); do_commit(); end
      else if (op < 6) begin load_ser(rand_word(), 40, 1); do_commit(); end
      else if (op == 6) begin
        if ($urandom % 2) load_par(rand_word(), $urandom % 5, 1);
        else load_ser(rand_word(), $urandom % 40, 1);
        do_commit();
      end else idle($urandom % 21);
    end
    idle(25);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule